// File: doc/BRIEF.md
# Bidirectional Parity Transceiver with Latch/Register Storage

This block moves a 16-bit word, split into byte lanes that each carry one parity bit, between two ports, A and B, in either direction. Each direction has its own storage stage, which a level-sensitive latch enable and an edge-sensitive strobe control. While the latch enable is high the stage is transparent. While it is low the stage holds its value, and it reloads only on a rising edge of that direction's strobe. Both control inputs are sampled on the block clock `clk`: a strobe edge is seen when the strobe is high on one `clk` edge after being low on the one before.

Each port's outputs are modelled as a tri-state drive: a data vector plus a drive-enable flag, which the active-low output enable gates. In the A-to-B direction the block can either generate the parity bits or check the incoming ones. The B-to-A direction always checks, and always forwards the received parity bits unchanged. One odd/even select is shared by both directions. Each direction has a combined error flag that covers all of its lanes and is forced low while that direction's outputs are released. A separate flag reports the illegal case where both directions drive at the same time.

Top module: `par_xcvr`

## Requirements
- R1: With a direction's latch enable high, its data and parity outputs equal its inputs in the same cycle, and a rising strobe edge has no effect.
- R2: With the latch enable low, the first `clk` edge at which the strobe is high after being low at the previous edge loads the inputs; later input changes do not reach the outputs.
- R3: With the latch enable low and no strobe rising edge, the outputs keep their value, whether the strobe stays high, stays low or falls.
- R4: When the latch enable falls while the strobe is already high, the value last passed through is held, and the strobe level that is still high loads nothing.
- R5: Output enable high releases that direction: its drive-enable is 0 and its error flag is 0.
- R6: With `a2b_gen`=1, parity bit k of `pb_out` is computed over byte k of `b_out` (bits 8k+7..8k), so that the 9-bit group holds an odd number of ones when `odd_sel`=1 and an even number when `odd_sel`=0; `pa_in` is ignored and `a2b_perr` stays 0.
- R7: With `a2b_gen`=0, `pb_out` forwards the stored `pa_in` bits, and `a2b_perr`=1 when any byte together with its parity bit has a ones count whose parity differs from `odd_sel`.
- R8: The B-to-A direction always checks in the same way as R7 (result on `b2a_perr`), and forwards `pb_in` to `pa_out`, whatever `a2b_gen` is set to.
- R9: The controls of one direction have no effect on the stored value or the outputs of the other.
- R10: `bus_conflict` is 1 exactly when both drive-enables are 1.
- R11: While `rst_n` is low, both drive-enables and `bus_conflict` are 0, and both storage stages clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the latch enables and strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity (both directions) |
| a2b_gen | input | 1 | A-to-B parity mode: 1 generate, 0 check |
| a2b_le | input | 1 | A-to-B latch enable (high = transparent) |
| a2b_ck | input | 1 | A-to-B load strobe |
| a2b_oe_n | input | 1 | A-to-B output enable, active low |
| a_in | input | 16 | Data received on port A |
| pa_in | input | 2 | Parity bits received on port A, one per byte |
| b2a_le | input | 1 | B-to-A latch enable |
| b2a_ck | input | 1 | B-to-A load strobe |
| b2a_oe_n | input | 1 | B-to-A output enable, active low |
| b_in | input | 16 | Data received on port B |
| pb_in | input | 2 | Parity bits received on port B |
| b_out | output | 16 | Drive data for port B |
| pb_out | output | 2 | Drive parity for port B |
| b_drv_en | output | 1 | Port B drive enable |
| a2b_perr | output | 1 | A-to-B combined parity error |
| a_out | output | 16 | Drive data for port A |
| pa_out | output | 2 | Drive parity for port A |
| a_drv_en | output | 1 | Port A drive enable |
| b2a_perr | output | 1 | B-to-A combined parity error |
| bus_conflict | output | 1 | Both directions drive at once |

## Verification
The bench drops the latch enable while the strobe is high and then changes the inputs. A design that treats the still-high strobe as an edge would load the new word instead of holding the old one. A high-to-low strobe transition is also applied with changing data, to catch a design that loads on either edge. In generate mode the bench feeds wrong parity on `pa_in`, so a design that leaks the input bit through, or that swaps the byte lanes, shows the wrong `pb_out`. The odd/even select is toggled on the same word to expose inverted polarity, and the two directions are run against each other so that crossed controls show up as a changed held value.

// File: rtl/par_xcvr_pkg.sv
package par_xcvr_pkg;

   // What the storage stage does on the coming clk edge
   typedef enum logic [1:0] {
      SM_HOLD        = 2'd0,
      SM_PASS        = 2'd1,
      SM_LOAD        = 2'd2
   } store_mode_e;

   // Parity mode of a direction
   typedef enum logic {
      PM_CHECK = 1'b0,
      PM_GEN   = 1'b1
   } par_mode_e;

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
   import par_xcvr_pkg::*;
#(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         le,
   input  logic         ck,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic         ck_q;
   logic         ck_rise;
   logic [W-1:0] held;
   store_mode_e  mode;

   assign ck_rise = ck & ~ck_q;

   always_comb begin
      if (le)           mode = SM_PASS;
      else if (ck_rise) mode = SM_LOAD;
      else              mode = SM_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_q <= 1'b0;
         held <= '0;
      end else begin
         ck_q <= ck;
         case (mode)
            SM_PASS, SM_LOAD: held <= d;
            default:          held <= held;
         endcase
      end
   end

   // transparent path bypasses the holding register
   assign q = (mode == SM_PASS) ? d : held;

endmodule

// File: rtl/xcvr_lane_parity.sv
module xcvr_lane_parity
   import par_xcvr_pkg::*;
#(
   parameter int LANE_W  = 8,
   parameter bit CAN_GEN = 1'b1
) (
   input  logic [LANE_W-1:0] data,
   input  logic              par_in,
   input  logic              odd_sel,
   input  par_mode_e         mode,
   output logic              par_out,
   output logic              err
);

   logic group_odd;
   assign group_odd = ^{data, par_in};

   if (CAN_GEN) begin : g_gen
      logic gen_bit;
      assign gen_bit = (^data) ^ odd_sel;
      assign par_out = (mode == PM_GEN) ? gen_bit : par_in;
      assign err     = (mode == PM_GEN) ? 1'b0 : (group_odd != odd_sel);
   end else begin : g_chk
      logic unused_mode;
      assign unused_mode = &{1'b0, mode};
      assign par_out = par_in;
      assign err     = (group_odd != odd_sel);
   end

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
   import par_xcvr_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int LANE_W  = 8,
   parameter bit CAN_GEN = 1'b1,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int ST_W   = DATA_W + LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              le,
   input  logic              ck,
   input  logic              oe_n,
   input  logic              odd_sel,
   input  par_mode_e         mode,
   input  logic [DATA_W-1:0] data_in,
   input  logic [LANES-1:0]  par_in,
   output logic [DATA_W-1:0] data_out,
   output logic [LANES-1:0]  par_out,
   output logic              drv_en,
   output logic              perr
);

   logic [ST_W-1:0]  st_q;
   logic [LANES-1:0] lane_err;
   logic [LANES-1:0] par_held;

   xcvr_store #(.W(ST_W)) store_i (
      .clk   (clk),
      .rst_n (rst_n),
      .le    (le),
      .ck    (ck),
      .d     ({par_in, data_in}),
      .q     (st_q)
   );

   assign data_out = st_q[DATA_W-1:0];
   assign par_held = st_q[ST_W-1:DATA_W];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      xcvr_lane_parity #(.LANE_W(LANE_W), .CAN_GEN(CAN_GEN)) par_i (
         .data    (data_out[l*LANE_W +: LANE_W]),
         .par_in  (par_held[l]),
         .odd_sel (odd_sel),
         .mode    (mode),
         .par_out (par_out[l]),
         .err     (lane_err[l])
      );
   end

   // reset forces the drive off regardless of the enable pin
   assign drv_en = rst_n & ~oe_n;
   assign perr   = drv_en & (|lane_err);

endmodule

// File: rtl/par_xcvr.sv
module par_xcvr
   import par_xcvr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              odd_sel,
   input  logic              a2b_gen,
   input  logic              a2b_le,
   input  logic              a2b_ck,
   input  logic              a2b_oe_n,
   input  logic [DATA_W-1:0] a_in,
   input  logic [LANES-1:0]  pa_in,
   input  logic              b2a_le,
   input  logic              b2a_ck,
   input  logic              b2a_oe_n,
   input  logic [DATA_W-1:0] b_in,
   input  logic [LANES-1:0]  pb_in,
   output logic [DATA_W-1:0] b_out,
   output logic [LANES-1:0]  pb_out,
   output logic              b_drv_en,
   output logic              a2b_perr,
   output logic [DATA_W-1:0] a_out,
   output logic [LANES-1:0]  pa_out,
   output logic              a_drv_en,
   output logic              b2a_perr,
   output logic              bus_conflict
);

   if (LANE_W < 1) begin : g_bad_lane
      $error("par_xcvr: LANE_W must be at least 1");
   end
   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("par_xcvr: DATA_W must be a multiple of LANE_W");
   end

   par_mode_e a2b_mode;
   assign a2b_mode = a2b_gen ? PM_GEN : PM_CHECK;

   xcvr_dir #(.DATA_W(DATA_W), .LANE_W(LANE_W), .CAN_GEN(1'b1)) a2b_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .le       (a2b_le),
      .ck       (a2b_ck),
      .oe_n     (a2b_oe_n),
      .odd_sel  (odd_sel),
      .mode     (a2b_mode),
      .data_in  (a_in),
      .par_in   (pa_in),
      .data_out (b_out),
      .par_out  (pb_out),
      .drv_en   (b_drv_en),
      .perr     (a2b_perr)
   );

   xcvr_dir #(.DATA_W(DATA_W), .LANE_W(LANE_W), .CAN_GEN(1'b0)) b2a_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .le       (b2a_le),
      .ck       (b2a_ck),
      .oe_n     (b2a_oe_n),
      .odd_sel  (odd_sel),
      .mode     (PM_CHECK),
      .data_in  (b_in),
      .par_in   (pb_in),
      .data_out (a_out),
      .par_out  (pa_out),
      .drv_en   (a_drv_en),
      .perr     (b2a_perr)
   );

   assign bus_conflict = b_drv_en & a_drv_en;

endmodule

// File: rtl/par_xcvr_chk.sv
module par_xcvr_chk #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              odd_sel,
   input logic              a2b_gen,
   input logic              a2b_le,
   input logic              a2b_ck,
   input logic              a2b_oe_n,
   input logic              b2a_oe_n,
   input logic [DATA_W-1:0] b_out,
   input logic [LANES-1:0]  pb_out,
   input logic              b_drv_en,
   input logic              a2b_perr,
   input logic              a_drv_en,
   input logic              b2a_perr,
   input logic              bus_conflict
);

   // R11: nothing drives while reset is held
   always_comb begin
      if (!rst_n) begin
         a_r11_quiet: assert (!b_drv_en && !a_drv_en && !bus_conflict);
      end
   end

   // R5: a released direction neither drives nor flags
   a_r5_b_released: assert property (@(posedge clk) disable iff (!rst_n)
      a2b_oe_n |-> (!b_drv_en && !a2b_perr));
   a_r5_a_released: assert property (@(posedge clk) disable iff (!rst_n)
      b2a_oe_n |-> (!a_drv_en && !b2a_perr));

   // R10: conflict flag tracks the two drive enables
   a_r10_conflict: assert property (@(posedge clk) disable iff (!rst_n)
      bus_conflict == (a_drv_en && b_drv_en));

   // R3: closed stage with strobe low at the last edge keeps its data
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!a2b_le && $past(!a2b_le) && $past(!a2b_ck)) |-> $stable(b_out));

   // R6: generated parity gives every lane the selected sense, no error
   a_r6_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      a2b_gen |-> !a2b_perr);
   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      a_r6_lane_sense: assert property (@(posedge clk) disable iff (!rst_n)
         a2b_gen |-> ((^{b_out[l*LANE_W +: LANE_W], pb_out[l]}) == odd_sel));
   end

endmodule

bind par_xcvr par_xcvr_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .odd_sel      (odd_sel),
   .a2b_gen      (a2b_gen),
   .a2b_le       (a2b_le),
   .a2b_ck       (a2b_ck),
   .a2b_oe_n     (a2b_oe_n),
   .b2a_oe_n     (b2a_oe_n),
   .b_out        (b_out),
   .pb_out       (pb_out),
   .b_drv_en     (b_drv_en),
   .a2b_perr     (a2b_perr),
   .a_drv_en     (a_drv_en),
   .b2a_perr     (b2a_perr),
   .bus_conflict (bus_conflict)
);

// File: tb/par_xcvr_tb_top.sv
`timescale 1ns/1ps
module par_xcvr_tb_top;

   localparam int SEL_BOUT = 0, SEL_PBOUT = 1, SEL_BDRV = 2, SEL_AOUT = 3,
                  SEL_PAOUT = 4, SEL_ADRV = 5, SEL_ABERR = 6, SEL_BAERR = 7,
                  SEL_CONF = 8;

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       req;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        odd_sel = 1'b0, a2b_gen = 1'b0;
   logic        a2b_le = 1'b1, a2b_ck = 1'b0, a2b_oe_n = 1'b0;
   logic        b2a_le = 1'b1, b2a_ck = 1'b0, b2a_oe_n = 1'b0;
   logic [15:0] a_in = 16'h1234, b_in = 16'h0;
   logic [1:0]  pa_in = 2'b0, pb_in = 2'b0;
   logic [15:0] b_out, a_out;
   logic [1:0]  pb_out, pa_out;
   logic        b_drv_en, a_drv_en, a2b_perr, b2a_perr, bus_conflict;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   exp_item_t sb_q[$];

   always #2.5 clk = ~clk;

   par_xcvr dut_i (
      .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .a2b_gen(a2b_gen),
      .a2b_le(a2b_le), .a2b_ck(a2b_ck), .a2b_oe_n(a2b_oe_n),
      .a_in(a_in), .pa_in(pa_in),
      .b2a_le(b2a_le), .b2a_ck(b2a_ck), .b2a_oe_n(b2a_oe_n),
      .b_in(b_in), .pb_in(pb_in),
      .b_out(b_out), .pb_out(pb_out), .b_drv_en(b_drv_en), .a2b_perr(a2b_perr),
      .a_out(a_out), .pa_out(pa_out), .a_drv_en(a_drv_en), .b2a_perr(b2a_perr),
      .bus_conflict(bus_conflict)
   );

   // bench model of a generated parity bit for one byte
   function automatic logic gen_bit(input logic [7:0] by, input logic odd);
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += by[i];
      return ((ones % 2) == 1) ? ~odd : odd;
   endfunction

   function automatic logic [31:0] actual(input int sel);
      case (sel)
         SEL_BOUT:  return {16'h0, b_out};
         SEL_PBOUT: return {30'h0, pb_out};
         SEL_BDRV:  return {31'h0, b_drv_en};
         SEL_AOUT:  return {16'h0, a_out};
         SEL_PAOUT: return {30'h0, pa_out};
         SEL_ADRV:  return {31'h0, a_drv_en};
         SEL_ABERR: return {31'h0, a2b_perr};
         SEL_BAERR: return {31'h0, b2a_perr};
         default:   return {31'h0, bus_conflict};
      endcase
   endfunction

   task automatic expect_val(input int sel, input logic [31:0] v, input string req);
      exp_item_t it;
      it.sel = sel; it.exp = v; it.req = req;
      sb_q.push_back(it);
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // monitor: checks every queued item just after the following clk edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (actual(it.sel) !== it.exp) begin
               fails++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel,
                        actual(it.sel), it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R11: reset with both enables pulled active
      step();
      expect_val(SEL_BDRV, 0, "R11"); expect_val(SEL_ADRV, 0, "R11");
      expect_val(SEL_CONF, 0, "R11");
      step();
      rst_n = 1'b1; a2b_le = 1'b0; b2a_le = 1'b0; b2a_oe_n = 1'b1;
      a_in = 16'hAAAA;
      expect_val(SEL_BOUT, 0, "R11"); expect_val(SEL_PBOUT, 0, "R11");
      expect_val(SEL_BDRV, 1, "R5"); expect_val(SEL_ABERR, 0, "R7");
      // R1: transparent follows input
      step(); a2b_le = 1'b1; a_in = 16'h1234;
      expect_val(SEL_BOUT, 16'h1234, "R1");
      step(); a_in = 16'hBEEF; pa_in = 2'b10;
      expect_val(SEL_BOUT, 16'hBEEF, "R1"); expect_val(SEL_PBOUT, 2'b10, "R1");
      step(); a2b_ck = 1'b1; a_in = 16'h0F0F; pa_in = 2'b00;
      expect_val(SEL_BOUT, 16'h0F0F, "R1");
      // R4: latch closes while strobe already high
      step(); a2b_le = 1'b0; a_in = 16'h5555;
      expect_val(SEL_BOUT, 16'h0F0F, "R4");
      step(); a_in = 16'h6666;
      expect_val(SEL_BOUT, 16'h0F0F, "R4");
      // R3: strobe falls, data changes
      step(); a2b_ck = 1'b0; a_in = 16'h7777;
      expect_val(SEL_BOUT, 16'h0F0F, "R3");
      // R2: rising strobe loads
      step(); a2b_ck = 1'b1; a_in = 16'h1357; pa_in = 2'b01;
      expect_val(SEL_BOUT, 16'h1357, "R2"); expect_val(SEL_PBOUT, 2'b01, "R2");
      step(); a_in = 16'h2468; pa_in = 2'b10;
      expect_val(SEL_BOUT, 16'h1357, "R2");
      step(); a2b_ck = 1'b0; a_in = 16'h0000;
      expect_val(SEL_BOUT, 16'h1357, "R3");
      // R7: check mode, even then odd
      step(); a2b_le = 1'b1; a_in = 16'h0301; pa_in = 2'b00;
      expect_val(SEL_ABERR, 1, "R7"); expect_val(SEL_PBOUT, 2'b00, "R7");
      step(); pa_in = 2'b01;
      expect_val(SEL_ABERR, 0, "R7");
      step(); odd_sel = 1'b1;
      expect_val(SEL_ABERR, 1, "R7");
      step(); pa_in = 2'b10;
      expect_val(SEL_ABERR, 0, "R7");
      // R6: generate mode, wrong pa_in is ignored
      step(); a2b_gen = 1'b1; pa_in = 2'b11;
      expect_val(SEL_PBOUT, {30'h0, gen_bit(8'h03, 1'b1), gen_bit(8'h01, 1'b1)}, "R6");
      expect_val(SEL_ABERR, 0, "R6");
      step(); odd_sel = 1'b0;
      expect_val(SEL_PBOUT, {30'h0, gen_bit(8'h03, 1'b0), gen_bit(8'h01, 1'b0)}, "R6");
      step(); a_in = 16'h7F00;
      expect_val(SEL_PBOUT, {30'h0, gen_bit(8'h7F, 1'b0), gen_bit(8'h00, 1'b0)}, "R6");
      // R5: release A-to-B with a bad check pattern present
      step(); a2b_gen = 1'b0; a_in = 16'h0001; pa_in = 2'b00; a2b_oe_n = 1'b1;
      expect_val(SEL_BDRV, 0, "R5"); expect_val(SEL_ABERR, 0, "R5");
      expect_val(SEL_BOUT, 16'h0001, "R5");
      // R8: B-to-A checks even when A-to-B generates
      step(); a2b_gen = 1'b1; b2a_oe_n = 1'b0; b2a_le = 1'b1;
      b_in = 16'h8001; pb_in = 2'b00;
      expect_val(SEL_AOUT, 16'h8001, "R8"); expect_val(SEL_BAERR, 1, "R8");
      expect_val(SEL_ADRV, 1, "R8"); expect_val(SEL_PAOUT, 2'b00, "R8");
      step(); pb_in = 2'b11;
      expect_val(SEL_BAERR, 0, "R8"); expect_val(SEL_PAOUT, 2'b11, "R8");
      // R9: close B-to-A, exercise A-to-B controls
      step(); b2a_le = 1'b0;
      expect_val(SEL_AOUT, 16'h8001, "R9");
      step(); b_in = 16'h1111; pb_in = 2'b00; a2b_le = 1'b1; a_in = 16'hC3C3;
      expect_val(SEL_AOUT, 16'h8001, "R9"); expect_val(SEL_PAOUT, 2'b11, "R9");
      step(); a2b_le = 1'b0; a2b_ck = 1'b0;
      step(); a2b_ck = 1'b1; a_in = 16'h3C3C;
      expect_val(SEL_AOUT, 16'h8001, "R9"); expect_val(SEL_BOUT, 16'h3C3C, "R9");
      // R9: B-to-A strobe loads without touching A-to-B
      step(); b2a_ck = 1'b1; b_in = 16'h00FF; a_in = 16'hFFFF;
      expect_val(SEL_AOUT, 16'h00FF, "R9"); expect_val(SEL_BOUT, 16'h3C3C, "R9");
      // R10: contention
      step(); a2b_oe_n = 1'b0;
      expect_val(SEL_CONF, 1, "R10");
      step(); b2a_oe_n = 1'b1;
      expect_val(SEL_CONF, 0, "R10"); expect_val(SEL_ADRV, 0, "R5");
      step(); step();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule